// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretcher and Watchdog

This block produces the system reset for a chip from a digital supply-good flag and a slow timebase tick. It drives a matched pair of reset outputs, one active high and one active low, that always carry opposite levels. Reset is held for as long as the supply is bad. Once the supply recovers, reset is held for a further fixed number of ticks.

The two reset pins are also read back as inputs. A rising edge on the active-high pin or a falling edge on the active-low pin starts a complete new reset pulse. A short external reset is therefore stretched to the full pulse length.

A watchdog counts ticks while the system runs. It is restarted by every change of level on the chip-select input, whether rising or falling. If it reaches its limit, it forces a full reset pulse. The watchdog stays cleared while the supply is bad, while a reset pulse is active, and while an external reset level is held on either pin. After a reset it starts again from zero.

With the default parameters and a 5 kHz tick, the pulse is 200 ms and the watchdog timeout is 1.6 s.

Top module: `supply_reset_supervisor`

## Requirements
- R1: While `supply_ok` is low, `rst_hi_out` is 1 and `rst_lo_out` is 0. Both outputs also hold these levels after the synchronous reset `rst_n`.
- R2: After `supply_ok` goes high, reset is released once exactly PULSE_TICKS tick cycles have been counted. With `tick` high on every cycle, release is seen after the PULSE_TICKS-th clock edge.
- R3: When `supply_ok` is sampled low, reset is asserted on that same clock edge.
- R4: A 0-to-1 change on `rst_hi_pin_in` restarts the reset pulse from a zero count. Because of the two-flop synchronizer and the edge flop, the output asserts on the third clock edge after the change.
- R5: A 1-to-0 change on `rst_lo_pin_in` restarts the reset pulse in the same way and with the same latency.
- R6: After WDT_TICKS tick cycles with no clear, the watchdog forces a full reset pulse. The watchdog count then starts again from zero.
- R7: Every change of level on `cs_in`, rising or falling, restarts the watchdog count from zero. This takes effect at the third clock edge after the change. A restart on the same edge as the final tick prevents the expiry.
- R8: The watchdog stays cleared while the supply is low, while the reset pulse is active, and while `rst_hi_pin_in` is held at 1 or `rst_lo_pin_in` is held at 0. It counts from zero once all of these conditions have ended.
- R9: `rst_lo_out` is the exact inverse of `rst_hi_out` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above trip threshold, synchronous to clk |
| tick | input | 1 | One-cycle timebase strobe (nominally 5 kHz) |
| cs_in | input | 1 | Chip select; either edge restarts the watchdog |
| rst_hi_pin_in | input | 1 | Readback of the active-high reset pin |
| rst_lo_pin_in | input | 1 | Readback of the active-low reset pin |
| rst_hi_out | output | 1 | Reset, active high |
| rst_lo_out | output | 1 | Reset, active low |

## Verification
The critical collision is a chip-select restart landing on the same edge as the watchdog's final tick. The restart must win, and no reset may appear until a full new timeout has elapsed. One directed case changes chip select exactly nine edges after a release, so that its synchronized edge meets the final tick. A long random phase with irregular ticks, chip-select toggles, external pin pulses and supply drops also produces such collisions, together with external edges that arrive during a running pulse. A behavioural model in the bench judges every cycle, and the directed cases measure pulse and timeout lengths against the expected counts.

// File: rtl/sup_rst_pkg.sv
// Shared types for the supply supervisor.
// Assumes: all event fields are single-cycle strobes in the clk domain,
// except ext_hold, which is a level.
package sup_rst_pkg;
    typedef struct packed {
        logic cs_toggle;  // chip select changed level
        logic hi_rise;    // active-high pin went 0->1
        logic lo_fall;    // active-low pin went 1->0
        logic ext_hold;   // an external reset level is present
    } pin_evt_t;
endpackage

// File: rtl/pin_sync_edge.sv
// Two-flop synchronizer plus one history flop for each bit of an input bus.
// Outputs the synchronized level and its value one cycle earlier.
// Assumes: inputs are asynchronous and slow compared with clk. IDLE gives
// the reset value of each bit, so no edge is seen when reset ends.
module pin_sync_edge #(
    parameter int unsigned     W    = 3,
    parameter logic [W-1:0]    IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic q1, q2, q3;
        // Move the bit through the synchronizer and the history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q1 <= IDLE[b];
                q2 <= IDLE[b];
                q3 <= IDLE[b];
            end else begin
                q1 <= din[b];
                q2 <= q1;
                q3 <= q2;
            end
        end
        assign lvl[b]  = q2;
        assign prev[b] = q3;
    end
endmodule

// File: rtl/reset_pulse_seq.sv
// Reset pulse sequencer. It holds reset while the supply is low and restarts
// the pulse on any restart strobe. It releases reset after PULSE_TICKS ticks.
// Assumes: tick is a one-cycle strobe. A bad supply or a restart takes
// priority over counting.
module reset_pulse_seq #(
    parameter int unsigned PULSE_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    input  logic restart,
    output logic active
);
    localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

    logic [PW-1:0] cnt;

    // Hold, restart or count down the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (!supply_ok || restart) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || restart) |=> (active && cnt == '0)); // R4

    AST_FULL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(cnt) == LAST && $past(tick))); // R2
endmodule

// File: rtl/watchdog_core.sv
// Watchdog tick counter. It raises expire for one cycle when WDT_TICKS ticks
// have passed with no clear or kick.
// Assumes: hold_clear is a level and kick is a strobe. Both take priority
// over the final tick.
module watchdog_core #(
    parameter int unsigned WDT_TICKS = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold_clear,
    input  logic kick,
    output logic expire
);
    localparam int unsigned WW = $clog2(WDT_TICKS + 1);
    localparam logic [WW-1:0] LAST = WW'(WDT_TICKS - 1);

    logic [WW-1:0] cnt;
    logic          clear;

    assign clear  = hold_clear | kick;
    assign expire = !clear && tick && (cnt == LAST);

    // Count ticks; return to zero on a clear or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_clear || kick) |=> (cnt == '0)); // R8

    AST_WDT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R6
endmodule

// File: rtl/supply_reset_supervisor.sv
// Top level of the supply supervisor. It synchronizes chip select and the
// two reset-pin readbacks and derives their edges. From these it drives the
// pulse sequencer and the watchdog.
// Assumes: supply_ok and tick are already synchronous to clk. The pins idle
// at hi=0 and lo=1.
module supply_reset_supervisor
    import sup_rst_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 1000,
    parameter int unsigned WDT_TICKS   = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic tick,
    input  logic cs_in,
    input  logic rst_hi_pin_in,
    input  logic rst_lo_pin_in,
    output logic rst_hi_out,
    output logic rst_lo_out
);
    localparam int unsigned NPIN = 3;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;  // {lo, hi, cs}

    logic [NPIN-1:0] pin_lvl, pin_prev;
    pin_evt_t        evt;
    logic            active, wdt_expire;

    pin_sync_edge #(.W(NPIN), .IDLE(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rst_lo_pin_in, rst_hi_pin_in, cs_in}),
        .lvl   (pin_lvl),
        .prev  (pin_prev)
    );

    // Decode edges and held levels from the synchronized pins.
    always_comb begin
        evt.cs_toggle = pin_lvl[0] ^ pin_prev[0];
        evt.hi_rise   = pin_lvl[1] & ~pin_prev[1];
        evt.lo_fall   = ~pin_lvl[2] & pin_prev[2];
        evt.ext_hold  = pin_lvl[1] | ~pin_lvl[2];
    end

    reset_pulse_seq #(.PULSE_TICKS(PULSE_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .tick      (tick),
        .restart   (evt.hi_rise | evt.lo_fall | wdt_expire),
        .active    (active)
    );

    watchdog_core #(.WDT_TICKS(WDT_TICKS)) u_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold_clear (!supply_ok | active | evt.ext_hold),
        .kick       (evt.cs_toggle),
        .expire     (wdt_expire)
    );

    assign rst_hi_out = active;
    assign rst_lo_out = ~active;

    AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (rst_hi_out && !rst_lo_out)); // R1 R3
endmodule

// File: tb/supply_reset_supervisor_tb_top.sv
// Bench for the supply supervisor. A behavioural model is compared with the
// outputs on every cycle, and directed cases measure pulse and timeout lengths.
module supply_reset_supervisor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE = 4;
    localparam int WDT   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0, sup = 1'b0, tick = 1'b0, cs = 1'b0, hip = 1'b0, lop = 1'b1;
    logic rst_hi_out, rst_lo_out;
    int   n_cmp = 0, n_bad = 0;
    bit   cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_supervisor #(.PULSE_TICKS(PULSE), .WDT_TICKS(WDT)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(sup), .tick(tick), .cs_in(cs),
        .rst_hi_pin_in(hip), .rst_lo_pin_in(lop),
        .rst_hi_out(rst_hi_out), .rst_lo_out(rst_lo_out));

    // Behavioural model: a 3-deep history per pin, plus pulse and watchdog counts.
    bit h_cs[3], h_hi[3], h_lo[3];
    bit m_act = 1'b1;
    int m_pc = 0, m_wc = 0;

    always @(posedge clk) begin
        bit cs_e, hi_r, lo_f, hold, clr, exp_w;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin h_cs[k] = 0; h_hi[k] = 0; h_lo[k] = 1; end
            m_act = 1; m_pc = 0; m_wc = 0;
        end else begin
            cs_e  = h_cs[1] != h_cs[2];
            hi_r  = h_hi[1] && !h_hi[2];
            lo_f  = !h_lo[1] && h_lo[2];
            hold  = h_hi[1] || !h_lo[1];
            clr   = !sup || m_act || hold || cs_e;
            exp_w = !clr && tick && (m_wc == WDT - 1);
            if (!sup || hi_r || lo_f || exp_w) begin
                m_act = 1; m_pc = 0;
            end else if (m_act && tick) begin
                if (m_pc == PULSE - 1) begin m_act = 0; m_pc = 0; end
                else m_pc++;
            end
            if (clr) m_wc = 0;
            else if (tick) m_wc = exp_w ? 0 : m_wc + 1;
            h_cs[2] = h_cs[1]; h_cs[1] = h_cs[0]; h_cs[0] = cs;
            h_hi[2] = h_hi[1]; h_hi[1] = h_hi[0]; h_hi[0] = hip;
            h_lo[2] = h_lo[1]; h_lo[1] = h_lo[0]; h_lo[0] = lop;
        end
    end

    // Per-cycle comparison against the model, covering R9 as well.
    always @(negedge clk) begin
        if (cmp_en) begin
            n_cmp++;
            if (rst_hi_out !== m_act || rst_lo_out !== !m_act) begin
                n_bad++;
                $display("FAIL MODEL/R9 t=%0t hi=%b lo=%b expected hi=%b lo=%b",
                         $time, rst_hi_out, rst_lo_out, m_act, !m_act);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until rst_hi_out reaches lvl.
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        while (rst_hi_out !== lvl && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        chk("R1 reset state hi", rst_hi_out, 1);
        chk("R1 reset state lo", rst_lo_out, 0);
        tick = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 supply low holds reset", rst_hi_out, 1);

        sup = 1'b1;                               // R2 pulse after supply rise
        wait_level(1'b0, n);
        chk("R2 pulse length after supply rise", n, PULSE);

        wait_level(1'b1, n);                      // R6 unkicked watchdog expiry
        chk("R6 watchdog timeout", n, WDT);
        wait_level(1'b0, n);
        chk("R6 forced pulse length", n, PULSE);

        repeat (9) @(negedge clk);                // R7 kick meets final tick
        cs = ~cs;
        wait_level(1'b1, n);
        chk("R7 kick on final tick suppresses expiry", n + 9, 2 * WDT);
        wait_level(1'b0, n);

        cs = ~cs;                                 // R7 falling edge kick
        wait_level(1'b1, n);
        chk("R7 cs falling restarts watchdog", n, 3 + WDT);
        wait_level(1'b0, n);
        cs = ~cs;                                 // R7 rising edge kick
        wait_level(1'b1, n);
        chk("R7 cs rising restarts watchdog", n, 3 + WDT);
        wait_level(1'b0, n);

        hip = 1'b1;                               // R4 external high-pin edge
        wait_level(1'b1, n);
        chk("R4 hi pin edge latency", n, 3);
        wait_level(1'b0, n);
        chk("R4 stretched pulse length", n, PULSE);
        repeat (20) @(negedge clk);
        chk("R8 held hi pin keeps watchdog cleared", rst_hi_out, 0);
        hip = 1'b0;
        wait_level(1'b1, n);
        chk("R8 watchdog restarts after hi release", n, 2 + WDT);
        wait_level(1'b0, n);

        lop = 1'b0;                               // R5 external low-pin edge
        wait_level(1'b1, n);
        chk("R5 lo pin edge latency", n, 3);
        wait_level(1'b0, n);
        chk("R5 stretched pulse length", n, PULSE);
        repeat (20) @(negedge clk);
        chk("R8 held lo pin keeps watchdog cleared", rst_hi_out, 0);
        lop = 1'b1;
        wait_level(1'b1, n);
        chk("R8 watchdog restarts after lo release", n, 2 + WDT);
        wait_level(1'b0, n);

        sup = 1'b0;                               // R3 immediate assertion
        @(negedge clk);
        chk("R3 supply fall asserts next edge", rst_hi_out, 1);
        chk("R9 low output inverse", rst_lo_out, 0);
        repeat (25) @(negedge clk);
        chk("R1 held while supply low", rst_hi_out, 1);
        sup = 1'b1;
        wait_level(1'b0, n);
        chk("R2 pulse after recovery", n, PULSE);

        begin : random_phase
            int hi_left = 0, lo_left = 0;
            for (int i = 0; i < 20000; i++) begin
                @(negedge clk);
                tick = ($urandom % 2) == 0;
                sup  = ($urandom % 300) != 0;
                if (($urandom % 30) == 0) cs = ~cs;
                if (hi_left > 0) hi_left--;
                else if (($urandom % 250) == 0) hi_left = 1 + $urandom % 30;
                hip = hi_left > 0;
                if (lo_left > 0) lo_left--;
                else if (($urandom % 250) == 0) lo_left = 1 + $urandom % 30;
                lop = !(lo_left > 0);
            end
        end
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule